// File: doc/BRIEF.md
# Toggle-Status Interrupt Vectoring Unit

This block gathers internal events of a multi-threaded processor core into one 32-bit status word. It steers two of those events, the performance-counter sources on status bits 16 and 17, to the trigger input of a chosen hardware thread. Hardware events set status bits. Software changes status bits only by toggling them: each 1 written flips the matching bit.

A trigger fires only when a status bit moves from 0 to 1. There is no mask register. Software silences a source by writing its vector register to a value whose valid flag is clear. Later it routes the source again, and if the bit is already set it clears the bit and sets it once more to raise a fresh trigger. Each hardware thread has one active-low trigger line. That line pulses low for a single cycle for each routed rising edge.

The register port uses a 2-bit word address:
- Address 0 is the status word.
- Address 1 is the vector for bit 16.
- Address 2 is the vector for bit 17.
- Address 3 is unused.

Top module: `tsv_irq_unit`

## Requirements
- R1: After reset the status word and both vector registers read zero, and every `trig_n` line is high.
- R2: A write to address 0 flips each status bit whose write-data bit is 1 and leaves each bit whose write-data bit is 0 unchanged. The new value is readable in the cycle after the write.
- R3: A 0-to-1 change of a routed source's status bit drives that thread's `trig_n` low for exactly one cycle. That cycle is the one following the clock edge at which the bit becomes set. A 1-to-0 change raises nothing.
- R4: An `evt_set` bit sets its status bit. An event on a bit that is already set raises no trigger.
- R5: If an event and a toggle write hit the same status bit in the same cycle, the bit ends up set.
- R6: A vector value holds a valid flag in bit 2 and a thread index in bits 1:0. Address 1 routes status bit 16 and address 2 routes status bit 17. While bit 2 is clear the source raises no trigger, whatever the index. Routing a source whose bit is already set raises no trigger.
- R7: A vector register reads back bits 2:0 of its last written value, with bits 31:3 reading zero. It keeps its value until it is written again.
- R8: Reading address 0 returns all 32 status bits in the same cycle. Address 3 reads zero.
- R9: Status bits other than 16 and 17 never raise a trigger.
- R10: If both routed sources rise in the same cycle, each target thread's line goes low for that one cycle. When both name the same thread, that thread sees a single one-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_addr | input | 2 | Register word address |
| bus_wen | input | 1 | Write strobe for the addressed register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| evt_set | input | 32 | Event pulses, one per status bit |
| trig_n | output | 4 | Active-low trigger, one per hardware thread |

## Verification
Reads are combinational. The bench therefore samples `bus_rdata` 1 ns after driving the address, which is still before the next edge, and compares it with the register values held before that edge.

A write or an event is captured at the next rising edge. Both the status word and the trigger lines change together, one edge after the stimulus. Each driver step pushes the expected trigger pattern into a queue, stamped with the following cycle number. The monitor compares that pattern at the falling edge of exactly that cycle.

An idle step after each trigger shows the line back high one cycle later. Reset release adds two cycles of synchronizer delay, which the bench waits out before its first step.

// File: rtl/tsv_pkg.sv
`timescale 1ns/1ps
package tsv_pkg;
  // register word addresses
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] ADDR_STATUS   = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_VEC_BASE = 2'd1;
  // number of sources that own a vector register
  localparam int N_VEC = 2;
endpackage

// File: rtl/tsv_rst_sync.sv
`timescale 1ns/1ps
module tsv_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_nxt;

  always_comb begin
    sync_nxt = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_nxt;
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/tsv_status_reg.sv
`timescale 1ns/1ps
module tsv_status_reg #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tog_en,
  input  logic [DATA_W-1:0] tog_mask,
  input  logic [DATA_W-1:0] evt_set,
  output logic [DATA_W-1:0] status,
  output logic [DATA_W-1:0] rise
);
  logic [DATA_W-1:0] stat_nxt;
  logic              stat_upd;

  // toggle first, then hardware sets override
  always_comb begin
    stat_nxt = status;
    if (tog_en) stat_nxt = stat_nxt ^ tog_mask;
    stat_nxt = stat_nxt | evt_set;
  end

  assign stat_upd = tog_en | (|evt_set);
  assign rise     = stat_nxt & ~status;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        status <= '0;
    else if (stat_upd) status <= stat_nxt;
  end

  assert_toggle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tog_en && evt_set == '0) |=> status == ($past(status) ^ $past(tog_mask)));

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tog_en && evt_set == '0) |=> $stable(status));

  assert_evt_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_set != '0) |=> ((status & $past(evt_set)) == $past(evt_set)));

  assert_evt_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tog_en && (tog_mask & evt_set) != '0) |=>
      ((status & $past(tog_mask & evt_set)) == $past(tog_mask & evt_set)));
endmodule

// File: rtl/tsv_vec_reg.sv
`timescale 1ns/1ps
module tsv_vec_reg #(
  parameter int VEC_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wen,
  input  logic [VEC_W-1:0] wdata,
  output logic [VEC_W-1:0] vec
);
  logic [VEC_W-1:0] vec_nxt;

  always_comb begin
    vec_nxt = vec;
    if (wen) vec_nxt = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   vec <= '0;
    else if (wen) vec <= vec_nxt;
  end

  assert_vec_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wen |=> vec == $past(wdata));

  assert_vec_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !wen |=> $stable(vec));
endmodule

// File: rtl/tsv_trig_route.sv
`timescale 1ns/1ps
module tsv_trig_route #(
  parameter int N_VEC    = 2,
  parameter int N_THREAD = 4,
  parameter int THR_W    = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [N_VEC-1:0]             src_rise,
  input  logic [N_VEC-1:0][THR_W:0]    vec,
  output logic [N_THREAD-1:0]          trig_n
);
  logic [N_THREAD-1:0] hit;
  logic [N_THREAD-1:0] trig_q;
  logic [N_VEC-1:0]    vec_valid;

  for (genvar v = 0; v < N_VEC; v++) begin : g_valid
    assign vec_valid[v] = vec[v][THR_W];
  end

  for (genvar t = 0; t < N_THREAD; t++) begin : g_thread
    always_comb begin
      hit[t] = 1'b0;
      for (int v = 0; v < N_VEC; v++) begin
        if (src_rise[v] && vec_valid[v] && (vec[v][THR_W-1:0] == THR_W'(t)))
          hit[t] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) trig_q <= '0;
    else        trig_q <= hit;
  end

  assign trig_n = ~trig_q;

  assert_trig_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|trig_q) |-> $past(|(src_rise & vec_valid)));

  assert_unrouted_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid == '0) |=> (trig_q == '0));

  assert_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (src_rise == '0) |=> (trig_q == '0));
endmodule

// File: rtl/tsv_irq_unit.sv
`timescale 1ns/1ps
module tsv_irq_unit #(
  parameter int DATA_W   = 32,
  parameter int N_THREAD = 4,
  parameter int SRC_A    = 16,
  parameter int SRC_B    = 17
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [tsv_pkg::ADDR_W-1:0] bus_addr,
  input  logic                      bus_wen,
  input  logic [DATA_W-1:0]         bus_wdata,
  output logic [DATA_W-1:0]         bus_rdata,
  input  logic [DATA_W-1:0]         evt_set,
  output logic [N_THREAD-1:0]       trig_n
);
  import tsv_pkg::*;

  localparam int THR_W = (N_THREAD > 1) ? $clog2(N_THREAD) : 1;
  localparam int VEC_W = THR_W + 1;
  localparam logic [DATA_W-1:0] VEC_SRC_MASK =
    (DATA_W'(1) << SRC_A) | (DATA_W'(1) << SRC_B);

  logic                         rst_int_n;
  logic                         stat_wen;
  logic [DATA_W-1:0]            status;
  logic [DATA_W-1:0]            rise;
  logic [N_VEC-1:0][VEC_W-1:0]  vec;
  logic [N_VEC-1:0]             vec_rise;

  tsv_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_int_n)
  );

  assign stat_wen = bus_wen && (bus_addr == ADDR_STATUS);

  tsv_status_reg #(.DATA_W(DATA_W)) u_status (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .tog_en   (stat_wen),
    .tog_mask (bus_wdata),
    .evt_set  (evt_set),
    .status   (status),
    .rise     (rise)
  );

  for (genvar v = 0; v < N_VEC; v++) begin : g_vec
    logic wen_v;
    assign wen_v = bus_wen && (bus_addr == (ADDR_VEC_BASE + ADDR_W'(v)));
    tsv_vec_reg #(.VEC_W(VEC_W)) u_vec (
      .clk   (clk),
      .rst_n (rst_int_n),
      .wen   (wen_v),
      .wdata (bus_wdata[VEC_W-1:0]),
      .vec   (vec[v])
    );
  end

  assign vec_rise = {rise[SRC_B], rise[SRC_A]};

  tsv_trig_route #(.N_VEC(N_VEC), .N_THREAD(N_THREAD), .THR_W(THR_W)) u_route (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .src_rise (vec_rise),
    .vec      (vec),
    .trig_n   (trig_n)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_STATUS) bus_rdata = status;
    for (int v = 0; v < N_VEC; v++) begin
      if (bus_addr == (ADDR_VEC_BASE + ADDR_W'(v)))
        bus_rdata = {{(DATA_W-VEC_W){1'b0}}, vec[v]};
    end
  end

  assert_only_vectored_R9: assert property (@(posedge clk) disable iff (!rst_int_n)
    ((rise & ~VEC_SRC_MASK) != '0 && vec_rise == '0) |=> (&trig_n));

  assert_reset_idle_R1: assert property (@(posedge clk)
    !rst_int_n |-> (&trig_n));
endmodule

// File: tb/tsv_irq_unit_bench.sv
`timescale 1ns/1ps
module tsv_irq_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  bus_addr;
  logic        bus_wen;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [31:0] evt_set;
  logic [3:0]  trig_n;

  always #2.5 clk = ~clk;

  tsv_irq_unit u_tsv_irq_unit (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wen(bus_wen),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_set(evt_set), .trig_n(trig_n)
  );

  typedef struct {
    int         due;
    logic [3:0] trig;
    string      req;
  } exp_t;

  exp_t        sb_q[$];
  int          cyc = 0;
  int          checks = 0;
  int          errors = 0;
  logic [31:0] m_stat = '0;
  logic [2:0]  m_vec [2] = '{3'd0, 3'd0};

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: compare trigger lines in the cycle each expectation is due
  always @(negedge clk) begin
    exp_t e;
    if (sb_q.size() > 0 && sb_q[0].due == cyc) begin
      e = sb_q.pop_front();
      check(e.req, {28'd0, trig_n}, {28'd0, e.trig});
    end
  end

  // driver: one cycle of stimulus, model update, expectation push
  task automatic step(input logic wen, input logic [1:0] addr, input logic [31:0] wd,
                      input logic [31:0] ev, input string req, input bit rd);
    logic [31:0] nxt, rise, exp_rd;
    logic [3:0]  et;
    @(negedge clk);
    bus_wen = wen; bus_addr = addr; bus_wdata = wd; evt_set = ev;
    if (rd) begin
      #1;
      if (addr == 2'd0)      exp_rd = m_stat;
      else if (addr == 2'd3) exp_rd = '0;
      else                   exp_rd = {29'd0, m_vec[int'(addr) - 1]};
      check(req, bus_rdata, exp_rd);
    end
    nxt = m_stat;
    if (wen && addr == 2'd0) nxt = nxt ^ wd;
    nxt = nxt | ev;
    rise = nxt & ~m_stat;
    et = 4'hF;
    for (int s = 0; s < 2; s++)
      if (rise[16 + s] && m_vec[s][2]) et[m_vec[s][1:0]] = 1'b0;
    m_stat = nxt;
    if (wen && (addr == 2'd1 || addr == 2'd2)) m_vec[int'(addr) - 1] = wd[2:0];
    sb_q.push_back('{cyc + 1, et, req});
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d, input string req);
    step(1'b1, a, d, '0, req, 1'b0);
  endtask
  task automatic rd(input logic [1:0] a, input string req);
    step(1'b0, a, '0, '0, req, 1'b1);
  endtask
  task automatic ev(input logic [31:0] m, input string req);
    step(1'b0, 2'd0, '0, m, req, 1'b0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    bus_addr = '0; bus_wen = 1'b0; bus_wdata = '0; evt_set = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R1", {28'd0, trig_n}, 32'h0000_000F);
    for (int a = 0; a < 3; a++) begin
      bus_addr = 2'(a); #1;
      check("R1", bus_rdata, 32'd0);
    end
    bus_addr = '0;
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    rd(2'd0, "R1"); rd(2'd1, "R1"); rd(2'd2, "R1");
    // toggles
    wr(2'd0, 32'h3, "R2"); rd(2'd0, "R8");
    wr(2'd0, 32'h1, "R2"); rd(2'd0, "R2");
    wr(2'd0, 32'h0, "R2"); rd(2'd0, "R2");
    // unrouted source
    wr(2'd0, 32'h0001_0000, "R6"); rd(2'd0, "R6");
    wr(2'd0, 32'h0001_0000, "R6");
    // vectors: A to thread 2, B with index but no valid flag
    wr(2'd1, 32'h6, "R7"); rd(2'd1, "R7");
    wr(2'd2, 32'hFFFF_FFF9, "R7"); rd(2'd2, "R7"); rd(2'd3, "R8");
    ev(32'h0002_0000, "R6"); wr(2'd0, 32'h0002_0000, "R6");
    // routed rising edge, one-cycle pulse, falling edge silent
    wr(2'd0, 32'h0001_0000, "R3"); rd(2'd1, "R3");
    wr(2'd0, 32'h0001_0000, "R3"); rd(2'd0, "R3");
    // hardware events
    ev(32'h0001_0000, "R4"); ev(32'h0001_0000, "R4"); rd(2'd0, "R4");
    // event and toggle on the same bit
    step(1'b1, 2'd0, 32'h0001_0000, 32'h0001_0000, "R5", 1'b0); rd(2'd0, "R5");
    wr(2'd0, 32'h0001_0000, "R5");
    step(1'b1, 2'd0, 32'h0001_0000, 32'h0001_0000, "R5", 1'b0); rd(2'd0, "R5");
    wr(2'd0, 32'h0001_0000, "R5");
    // non-vectored sources
    ev(32'h8000_0021, "R9"); rd(2'd0, "R9"); wr(2'd0, 32'h8000_0021, "R9");
    // both sources at once: same thread, then different threads
    wr(2'd2, 32'h6, "R10"); ev(32'h0003_0000, "R10"); rd(2'd0, "R10");
    wr(2'd0, 32'h0003_0000, "R10");
    wr(2'd1, 32'h4, "R10"); ev(32'h0003_0000, "R10"); rd(2'd0, "R10");
    wr(2'd0, 32'h0003_0000, "R10");
    // masking by clearing the vector, then rerouting and retriggering
    wr(2'd1, 32'h0, "R6"); wr(2'd0, 32'h0001_0000, "R6");
    wr(2'd1, 32'h5, "R6"); rd(2'd1, "R6");
    wr(2'd0, 32'h0001_0000, "R6"); wr(2'd0, 32'h0001_0000, "R3"); rd(2'd0, "R3");
    step(1'b0, 2'd0, '0, '0, "R3", 1'b0);
    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule